// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (256 x 16)

This block models a nonvolatile word memory of 256 sixteen-bit words behind a three-wire serial slave port (chip select, serial clock, data in) with a single data-out line. All three inputs are asynchronous to the system clock. They are brought into the clock domain by synchronisers, and the block acts only on rising edges of the serial clock that it detects there. A host raises chip select, sends a start bit, a two-bit opcode and an eight-bit address, and for write-type commands sixteen data bits. Programming is self-timed by a cycle counter, and the host polls completion on the data-out line.

Data out is presented as a value plus an output-enable. When the enable is low, the line is considered high impedance. The enable is high while a read streams words out, and while the ready/busy status is shown after chip select is raised again following a programming command.

Top module: `serial_eeprom`

## Requirements
- R1: While chip select is high, serial clock rising edges with data-in low are ignored. The first rising edge with data-in high is the start bit of a frame.
- R2: After the start bit, two opcode bits and eight address bits (MSB first) are taken, one per rising edge. Opcode 2'b10 reads. For a read, the edge carrying the last address bit drives DO to a dummy 0 with DO enabled. Each following rising edge presents the next data bit, MSB first.
- R3: When a read keeps clocking after the 16th data bit, it continues with the next address, wrapping from 8'hFF to 8'h00, with no further dummy bit.
- R4: Opcode 2'b01 takes 16 data bits after the address (27 clocks in total) and replaces the addressed word with exactly that value, regardless of its previous content, once the program time has elapsed.
- R5: Chip select low forces DO to high impedance and aborts any partly received frame without effect.
- R6: Opcode 2'b11 sets the addressed word to 16'hFFFF. Opcode 2'b00 with address bits [7:6] = 2'b10 sets every word to 16'hFFFF.
- R7: Opcode 2'b00 with address bits [7:6] = 2'b01, followed by 16 data bits, writes that value into every word.
- R8: Opcode 2'b00 with address bits [7:6] = 2'b11 sets the write-enable latch, and 2'b00 clears it. The latch is clear after reset. Erase, write, erase-all and write-all frames leave memory unchanged while it is clear.
- R9: Once a programming command has been accepted and chip select is low and then high again, DO is enabled and shows 0 while programming runs and 1 once it is done. Start bits are not accepted while programming runs.
- R10: After the final clock of a command, further serial clock edges and data-in are ignored until chip select goes low.
- R11: After reset, DO is disabled and every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Data-out enable; low means high impedance |

## Verification
Words are written and read back from a table of patterns: alternating bits, a lone MSB, a lone LSB, all-but-LSB, and mixed nibbles. These separate bit-order, off-by-one and stuck-bit faults in the shift paths. The extremes of the address space are used so that a sequential read across 8'hFF shows whether the address wraps to 0 and whether a second dummy bit appears. An overwrite from a value with set bits to one with cleared bits shows whether the old content is erased first. Each special command is told apart by its effect on words it should and should not touch. Frames sent while the latch is clear, after a completed command, or cut short by chip select must leave memory unchanged.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMD   = 3'd1,
        ST_WDATA = 3'd2,
        ST_READ  = 3'd3,
        ST_DONE  = 3'd4
    } see_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } see_op_e;

    typedef enum logic [1:0] {
        EX_WDIS = 2'b00,
        EX_WRAL = 2'b01,
        EX_ERAL = 2'b10,
        EX_WEN  = 2'b11
    } see_ext_e;

endpackage

// File: rtl/see_sync.sv
module see_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/see_prog_timer.sv
module see_prog_timer #(
    parameter int unsigned PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = TW'(PROG_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == TW'(1));
endmodule

// File: rtl/see_array.sv
module see_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) word_q[i] <= '1;
        end else if (we_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (all_i || (wr_addr_i == ADDR_W'(i))) word_q[i] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = word_q[rd_addr_i];
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom
    import serial_eeprom_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned PROG_CYCLES = 5000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int unsigned CMD_BITS = 2 + ADDR_W;
    localparam int unsigned CNT_W    = $clog2(CMD_BITS + WORD_W);
    localparam int unsigned IDX_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] BIT_LAST  = IDX_W'(WORD_W - 1);

    typedef struct packed {
        see_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] rd_sh;
        logic [IDX_W-1:0]  idx;
        logic              dout;
        logic              wen;
        logic              status;
        logic              pg_all;
        logic [ADDR_W-1:0] pg_addr;
        logic [WORD_W-1:0] pg_data;
    } ctl_t;

    // input synchronisation and edge detection
    logic cs_s, sclk_s, di_s;
    logic sclk_prev_q;
    logic sclk_rise;

    see_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sclk_i, di_i}),
        .sync_o  ({cs_s, sclk_s, di_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;

    // control state
    ctl_t              ctl_d, ctl_q;
    logic              prog_start;
    logic              busy;
    logic              prog_done;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;

    see_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy),
        .done_o  (prog_done)
    );

    see_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (prog_done),
        .all_i     (ctl_q.pg_all),
        .wr_addr_i (ctl_q.pg_addr),
        .wr_data_i (ctl_q.pg_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // read address: the word being decoded, or the next word of a stream
    always_comb begin
        if (ctl_q.st == ST_READ) rd_addr = ctl_q.addr + ADDR_W'(1);
        else                     rd_addr = {ctl_q.sh[ADDR_W-2:0], di_s};
    end

    always_comb begin
        logic [ADDR_W-1:0] ad;
        logic [1:0]        op_b;
        logic [1:0]        ext_b;
        logic              launch;
        logic              l_all;
        logic [ADDR_W-1:0] l_addr;
        logic [WORD_W-1:0] l_data;

        ctl_d      = ctl_q;
        prog_start = 1'b0;
        launch     = 1'b0;
        l_all      = 1'b0;
        l_addr     = ctl_q.addr;
        l_data     = '1;
        ad         = '0;
        op_b       = '0;
        ext_b      = '0;

        if (!cs_s) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.cnt = '0;
        end else if (sclk_rise) begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    if (di_s && !busy) begin
                        ctl_d.st     = ST_CMD;
                        ctl_d.cnt    = '0;
                        ctl_d.status = 1'b0;
                    end
                end
                ST_CMD: begin
                    ctl_d.sh  = {ctl_q.sh[WORD_W-2:0], di_s};
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    if (ctl_q.cnt == CMD_LAST) begin
                        op_b       = ctl_d.sh[CMD_BITS-1:CMD_BITS-2];
                        ad         = ctl_d.sh[ADDR_W-1:0];
                        ext_b      = ad[ADDR_W-1:ADDR_W-2];
                        ctl_d.op   = op_b;
                        ctl_d.addr = ad;
                        ctl_d.cnt  = '0;
                        l_addr     = ad;
                        unique case (see_op_e'(op_b))
                            OP_READ: begin
                                ctl_d.st    = ST_READ;
                                ctl_d.dout  = 1'b0;
                                ctl_d.rd_sh = rd_data;
                                ctl_d.idx   = '0;
                            end
                            OP_WRITE: ctl_d.st = ST_WDATA;
                            OP_ERASE: begin
                                ctl_d.st = ST_DONE;
                                launch   = 1'b1;
                            end
                            OP_EXT: begin
                                ctl_d.st = ST_DONE;
                                unique case (see_ext_e'(ext_b))
                                    EX_WEN:  ctl_d.wen = 1'b1;
                                    EX_WDIS: ctl_d.wen = 1'b0;
                                    EX_ERAL: begin
                                        launch = 1'b1;
                                        l_all  = 1'b1;
                                    end
                                    EX_WRAL: ctl_d.st = ST_WDATA;
                                    default: ctl_d.st = ST_DONE;
                                endcase
                            end
                            default: ctl_d.st = ST_DONE;
                        endcase
                    end
                end
                ST_WDATA: begin
                    ctl_d.sh  = {ctl_q.sh[WORD_W-2:0], di_s};
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                    if (ctl_q.cnt == DATA_LAST) begin
                        ctl_d.st = ST_DONE;
                        launch   = 1'b1;
                        l_all    = (ctl_q.op == OP_EXT);
                        l_data   = ctl_d.sh;
                    end
                end
                ST_READ: begin
                    ctl_d.dout = ctl_q.rd_sh[WORD_W-1];
                    if (ctl_q.idx == BIT_LAST) begin
                        ctl_d.addr  = ctl_q.addr + ADDR_W'(1);
                        ctl_d.rd_sh = rd_data;
                        ctl_d.idx   = '0;
                    end else begin
                        ctl_d.rd_sh = {ctl_q.rd_sh[WORD_W-2:0], 1'b0};
                        ctl_d.idx   = ctl_q.idx + IDX_W'(1);
                    end
                end
                ST_DONE: ctl_d.st = ST_DONE;
                default: ctl_d.st = ST_IDLE;
            endcase
        end

        if (launch && ctl_q.wen) begin
            prog_start    = 1'b1;
            ctl_d.status  = 1'b1;
            ctl_d.pg_all  = l_all;
            ctl_d.pg_addr = l_addr;
            ctl_d.pg_data = l_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // data-out drive
    logic status_mode;
    assign status_mode = cs_s && ctl_q.status && (ctl_q.st == ST_IDLE);
    assign do_oe_o     = cs_s && ((ctl_q.st == ST_READ) || status_mode);
    assign do_o        = status_mode ? ~busy
                                     : (cs_s && (ctl_q.st == ST_READ) && ctl_q.dout);
endmodule

// File: rtl/serial_eeprom_chk.sv
module serial_eeprom_chk
    import serial_eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_i,
    input logic       cs_s,
    input logic       sclk_rise,
    input see_state_e st,
    input logic       busy,
    input logic       prog_start,
    input logic       wen,
    input logic       do_o,
    input logic       do_oe_o
);
    // R5: chip select held low reaches the output as high impedance
    a_r5_cs_low_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_i && $past(!cs_i) && $past(!cs_i, 2)) |-> !do_oe_o);

    // R9: an enabled output during programming reports busy as 0
    a_r9_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_oe_o) |-> !do_o);

    // R9: no new programming cycle starts while one runs
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy);

    // R8: programming only starts with the write-enable latch set
    a_r8_wen_gate: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen);

    // R1: without a serial clock edge the control state holds
    a_r1_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !sclk_rise) |=> $stable(st));

    // R10: a completed command stays completed while chip select is high
    a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && cs_s) |=> (st == ST_DONE));
endmodule

bind serial_eeprom serial_eeprom_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs_i),
    .cs_s       (cs_s),
    .sclk_rise  (sclk_rise),
    .st         (ctl_q.st),
    .busy       (busy),
    .prog_start (prog_start),
    .wen        (ctl_q.wen),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o)
);

// File: tb/serial_eeprom_bench.sv
module serial_eeprom_bench;
    localparam int PROG = 40;
    localparam int NVEC = 6;
    // {address, data}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 16'hA5C3}, {8'hFF, 16'h1234}, {8'h7E, 16'h0001},
        {8'h80, 16'h8000}, {8'h01, 16'hFFFE}, {8'h3C, 16'h0F0F}
    };

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
    logic do_w, oe_w;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    serial_eeprom #(.PROG_CYCLES(PROG)) u_serial_eeprom (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .di_i(di),
        .do_o(do_w), .do_oe_o(oe_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic d, output logic q);
        di = d;
        repeat (4) @(posedge clk);
        sclk = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        q = do_w;
        sclk = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic cs_up;
        cs = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic cs_down;
        cs = 1'b0;
        di = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    task automatic wait_prog;
        repeat (PROG + 10) @(posedge clk);
    endtask

    task automatic frame(input logic [1:0] op, input logic [7:0] a, output logic last);
        logic q;
        bit_io(1'b1, q);
        bit_io(op[1], q);
        bit_io(op[0], q);
        for (int i = 7; i >= 0; i--) bit_io(a[i], q);
        last = q;
    endtask

    task automatic get_word(output logic [15:0] w);
        logic q;
        for (int i = 15; i >= 0; i--) begin
            bit_io(1'b0, q);
            w[i] = q;
        end
    endtask

    task automatic put_word(input logic [15:0] w);
        logic q;
        for (int i = 15; i >= 0; i--) bit_io(w[i], q);
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] w, output logic dummy);
        cs_up;
        frame(2'b10, a, dummy);
        get_word(w);
        cs_down;
    endtask

    task automatic wr(input logic [1:0] op, input logic [7:0] a, input logic [15:0] w);
        logic q;
        cs_up;
        frame(op, a, q);
        put_word(w);
        cs_down;
        wait_prog;
    endtask

    task automatic cmd(input logic [1:0] op, input logic [7:0] a);
        logic q;
        cs_up;
        frame(op, a, q);
        cs_down;
        wait_prog;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] w, w2, w3;
        logic dm, q;

        // R11: reset state
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R11 oe after reset", 32'(oe_w), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        rd(8'h00, w, dm);
        chk("R11 erased word after reset", 32'(w), 32'hFFFF);
        chk("R2 dummy zero", 32'(dm), 32'd0);

        // R8: write with latch clear is ignored
        wr(2'b01, 8'h05, 16'h1234);
        rd(8'h05, w, dm);
        chk("R8 write ignored while disabled", 32'(w), 32'hFFFF);

        // R8: set latch; table of patterns, R4 and R2
        cmd(2'b00, 8'hC0);
        for (int i = 0; i < NVEC; i++) wr(2'b01, VEC[i][23:16], VEC[i][15:0]);
        for (int i = 0; i < NVEC; i++) begin
            rd(VEC[i][23:16], w, dm);
            chk("R4 write then read", 32'(w), 32'(VEC[i][15:0]));
            chk("R2 dummy before data", 32'(dm), 32'd0);
        end

        // R3: sequential read wraps 0xFF -> 0x00 with no extra dummy
        cs_up;
        frame(2'b10, 8'hFF, dm);
        get_word(w);
        get_word(w2);
        get_word(w3);
        cs_down;
        chk("R3 first word", 32'(w), 32'h1234);
        chk("R3 wrapped to address 0", 32'(w2), 32'hA5C3);
        chk("R3 continues to address 1", 32'(w3), 32'hFFFE);

        // R1: leading zero clocks before the start bit
        cs_up;
        for (int i = 0; i < 3; i++) bit_io(1'b0, q);
        frame(2'b10, 8'h7E, dm);
        get_word(w);
        cs_down;
        chk("R1 leading zeros ignored", 32'(w), 32'h0001);

        // R4: overwrite erases first
        wr(2'b01, 8'h3C, 16'hF0F0);
        rd(8'h3C, w, dm);
        chk("R4 overwrite", 32'(w), 32'hF0F0);

        // R6: single erase
        cmd(2'b11, 8'h80);
        rd(8'h80, w, dm);
        chk("R6 erase word", 32'(w), 32'hFFFF);

        // R10: frame after a completed command is ignored
        cs_up;
        frame(2'b11, 8'h3C, q);
        frame(2'b01, 8'h3C, q);
        put_word(16'h0000);
        cs_down;
        wait_prog;
        rd(8'h3C, w, dm);
        chk("R10 trailing frame ignored", 32'(w), 32'hFFFF);

        // R5: aborted write
        cs_up;
        frame(2'b01, 8'h01, q);
        for (int i = 0; i < 8; i++) bit_io(1'b0, q);
        cs_down;
        @(negedge clk);
        chk("R5 oe low with cs low", 32'(oe_w), 32'd0);
        wait_prog;
        rd(8'h01, w, dm);
        chk("R5 aborted write no effect", 32'(w), 32'hFFFE);

        // R9: status polling
        cs_up;
        frame(2'b01, 8'h02, q);
        put_word(16'hABCD);
        cs_down;
        cs_up;
        @(negedge clk);
        chk("R9 status enabled", 32'(oe_w), 32'd1);
        chk("R9 busy reads 0", 32'(do_w), 32'd0);
        wait_prog;
        @(negedge clk);
        chk("R9 ready reads 1", 32'(do_w), 32'd1);
        cs_down;
        rd(8'h02, w, dm);
        chk("R9 programmed value", 32'(w), 32'hABCD);

        // R9/R5: cs low for the whole cycle keeps DO disabled
        cs_up;
        frame(2'b01, 8'h03, q);
        put_word(16'hDEAD);
        cs_down;
        repeat (PROG / 2) @(posedge clk);
        @(negedge clk);
        chk("R9 hiz when cs stays low", 32'(oe_w), 32'd0);
        wait_prog;
        rd(8'h03, w, dm);
        chk("R4 word after hidden cycle", 32'(w), 32'hDEAD);

        // R7: write all
        wr(2'b00, 8'h40, 16'h3C3C);
        rd(8'h00, w, dm);
        chk("R7 write-all low address", 32'(w), 32'h3C3C);
        rd(8'hFF, w, dm);
        chk("R7 write-all high address", 32'(w), 32'h3C3C);

        // R6: erase all
        cmd(2'b00, 8'h80);
        rd(8'h7E, w, dm);
        chk("R6 erase-all", 32'(w), 32'hFFFF);

        // R8: disable, then write ignored
        cmd(2'b00, 8'h00);
        wr(2'b01, 8'h10, 16'h1111);
        rd(8'h10, w, dm);
        chk("R8 write ignored after disable", 32'(w), 32'hFFFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule